// File: doc/BRIEF.md
# Register Alias Table for Three-Wide Renaming

This block keeps, for each architectural register, the current answer to one question: which in-flight reorder-buffer slot will produce the register's newest value, if any? When no slot is pending, the value is read from the committed register file. Each cycle, up to three operations arrive in program order, one per lane. Each operation carries two source register numbers, one destination register number, a write-enable flag and a reorder-buffer tag that was allocated upstream. The block returns, for every source, a slot tag and an in-flight flag. A clear flag means the operand comes from the committed file.

Dependencies inside a group are resolved in the same cycle. A source in a later lane sees the destination of an earlier lane in the same group. When an entry retires, the mapping for its register falls back to the committed file, but only if no younger rename has taken that register over in the meantime. A flush returns every register to the committed file in one cycle.

Top module: `reg_alias_table`

## Requirements
- R1: After reset, every register reads with the in-flight flag clear, and its tag reads 0.
- R2: A source whose register is not written by an earlier live lane of the same group returns the table entry as it stood at the start of the cycle: the in-flight flag and the 6-bit slot tag. The table state is read through these outputs.
- R3: A source whose register is written by one or more earlier live lanes of the same group returns in-flight = 1 and the tag of the latest such lane. A lane's index is its program order, with lane 0 the oldest.
- R4: A live lane (op_valid = 1 and op_writes = 1, with no flush) makes its destination read as in-flight with that lane's tag from the next cycle on.
- R5: When several live lanes of one group write the same register, the table keeps the tag of the highest-numbered lane.
- R6: A retire of (register r, tag t) clears r's in-flight flag only if the table maps r to t at that time. A retire whose tag does not match leaves the entry unchanged.
- R7: When a retire and a live rename hit the same register in the same cycle, the rename wins.
- R8: A flush clears every in-flight flag in the next cycle. Renames and retires presented in the flush cycle are discarded.
- R9: A lane with op_valid = 0 or op_writes = 0 neither updates the table nor forwards its tag to later lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Return all registers to the committed file |
| op_valid | input | 3 | Lane k holds an operation |
| op_writes | input | 3 | Lane k writes its destination |
| op_src_a | input | 9 | First source register, 3 bits per lane |
| op_src_b | input | 9 | Second source register, 3 bits per lane |
| op_dst | input | 9 | Destination register, 3 bits per lane |
| op_tag | input | 18 | Allocated slot tag, 6 bits per lane |
| ret_valid | input | 1 | A retire is presented |
| ret_reg | input | 3 | Register of the retiring entry |
| ret_tag | input | 6 | Slot tag of the retiring entry |
| src_a_tag | output | 18 | Renamed first-source tag per lane |
| src_a_inflight | output | 3 | First source is pending in a slot |
| src_b_tag | output | 18 | Renamed second-source tag per lane |
| src_b_inflight | output | 3 | Second source is pending in a slot |

## Verification
The bench builds the block with its defaults: eight registers, forty slots and three lanes. With three lanes, a two-deep forwarding chain inside a group can occur, and lanes 0 through 2 can all write the same register. The 6-bit tag covers slots 0 to 39, so random tags exercise the whole slot range. Retires are aimed at both matching and stale tags. Flushes are mixed into the stream and coincide with renames.

// File: rtl/reg_alias_table.sv
module reg_alias_table #(
  parameter int ARCH_REGS = 8,
  parameter int ROB_SLOTS = 40,
  parameter int LANES     = 3,
  localparam int REG_W    = $clog2(ARCH_REGS),
  localparam int TAG_W    = $clog2(ROB_SLOTS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic [LANES-1:0]       op_valid,
  input  logic [LANES-1:0]       op_writes,
  input  logic [LANES*REG_W-1:0] op_src_a,
  input  logic [LANES*REG_W-1:0] op_src_b,
  input  logic [LANES*REG_W-1:0] op_dst,
  input  logic [LANES*TAG_W-1:0] op_tag,
  input  logic                   ret_valid,
  input  logic [REG_W-1:0]       ret_reg,
  input  logic [TAG_W-1:0]       ret_tag,
  output logic [LANES*TAG_W-1:0] src_a_tag,
  output logic [LANES-1:0]       src_a_inflight,
  output logic [LANES*TAG_W-1:0] src_b_tag,
  output logic [LANES-1:0]       src_b_inflight
);

  logic [ARCH_REGS-1:0]             busy_q;
  logic [ARCH_REGS-1:0][TAG_W-1:0]  tag_q;
  logic [LANES-1:0]                 live;

  assign live = op_valid & op_writes;

  function automatic logic [TAG_W:0] resolve(
    input int                              k,
    input logic [REG_W-1:0]                r,
    input logic [ARCH_REGS-1:0]            bz,
    input logic [ARCH_REGS-1:0][TAG_W-1:0] tg,
    input logic [LANES-1:0]                lv,
    input logic [LANES*REG_W-1:0]          dst,
    input logic [LANES*TAG_W-1:0]          tags
  );
    logic [TAG_W:0] v;
    v = {bz[r], tg[r]};
    for (int j = 0; j < LANES; j++)
      if (j < k && lv[j] && dst[j*REG_W +: REG_W] == r)
        v = {1'b1, tags[j*TAG_W +: TAG_W]};
    return v;
  endfunction

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign {src_a_inflight[k], src_a_tag[k*TAG_W +: TAG_W]} =
      resolve(k, op_src_a[k*REG_W +: REG_W], busy_q, tag_q, live, op_dst, op_tag);
    assign {src_b_inflight[k], src_b_tag[k*TAG_W +: TAG_W]} =
      resolve(k, op_src_b[k*REG_W +: REG_W], busy_q, tag_q, live, op_dst, op_tag);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= '0;
      tag_q  <= '0;
    end else if (flush) begin
      busy_q <= '0;
    end else begin
      if (ret_valid && tag_q[ret_reg] == ret_tag)
        busy_q[ret_reg] <= 1'b0;
      for (int k = 0; k < LANES; k++)
        if (live[k]) begin
          busy_q[op_dst[k*REG_W +: REG_W]] <= 1'b1;
          tag_q[op_dst[k*REG_W +: REG_W]]  <= op_tag[k*TAG_W +: TAG_W];
        end
    end
  end

endmodule

// File: rtl/reg_alias_table_chk.sv
module reg_alias_table_chk #(
  parameter int ARCH_REGS = 8,
  parameter int LANES     = 3,
  parameter int REG_W     = 3,
  parameter int TAG_W     = 6
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             flush,
  input logic [LANES-1:0]                 op_valid,
  input logic [LANES-1:0]                 op_writes,
  input logic [LANES*REG_W-1:0]           op_src_a,
  input logic [LANES*REG_W-1:0]           op_dst,
  input logic [LANES*TAG_W-1:0]           op_tag,
  input logic                             ret_valid,
  input logic [REG_W-1:0]                 ret_reg,
  input logic [TAG_W-1:0]                 ret_tag,
  input logic [LANES*TAG_W-1:0]           src_a_tag,
  input logic [LANES-1:0]                 src_a_inflight,
  input logic [ARCH_REGS-1:0]             busy_q,
  input logic [ARCH_REGS-1:0][TAG_W-1:0]  tag_q
);
  logic [LANES-1:0] lv;
  logic [REG_W-1:0] last_dst;
  logic [TAG_W-1:0] last_tag;
  logic             ret_hit_by_rename;
  logic             ret_busy;

  assign lv       = op_valid & op_writes;
  assign last_dst = op_dst[(LANES-1)*REG_W +: REG_W];
  assign last_tag = op_tag[(LANES-1)*TAG_W +: TAG_W];
  assign ret_busy = busy_q[ret_reg];

  always_comb begin
    ret_hit_by_rename = 1'b0;
    for (int k = 0; k < LANES; k++)
      if (lv[k] && op_dst[k*REG_W +: REG_W] == ret_reg) ret_hit_by_rename = 1'b1;
  end

  assert_lane1_forward_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lv[0] && op_src_a[REG_W +: REG_W] == op_dst[0 +: REG_W])
      |-> (src_a_inflight[1] && src_a_tag[TAG_W +: TAG_W] == op_tag[0 +: TAG_W]));

  assert_last_lane_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lv[LANES-1] && !flush)
      |=> (busy_q[$past(last_dst)] && tag_q[$past(last_dst)] == $past(last_tag)));

  assert_stale_retire_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !flush && !ret_hit_by_rename && tag_q[ret_reg] != ret_tag)
      |=> (busy_q[$past(ret_reg)] == $past(ret_busy)));

  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (busy_q == '0));

  assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lv == '0 && !ret_valid && !flush) |=> $stable(busy_q));
endmodule

bind reg_alias_table reg_alias_table_chk #(
  .ARCH_REGS(ARCH_REGS), .LANES(LANES), .REG_W(REG_W), .TAG_W(TAG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .op_valid(op_valid),
  .op_writes(op_writes), .op_src_a(op_src_a), .op_dst(op_dst), .op_tag(op_tag),
  .ret_valid(ret_valid), .ret_reg(ret_reg), .ret_tag(ret_tag),
  .src_a_tag(src_a_tag), .src_a_inflight(src_a_inflight),
  .busy_q(busy_q), .tag_q(tag_q)
);

// File: tb/sim_reg_alias_table.sv
module sim_reg_alias_table;
  logic clk = 0, rst_n = 0, flush = 0;
  logic [2:0] v = 0, w = 0;
  logic [2:0] sa [3], sb [3], d [3];
  logic [5:0] t [3];
  logic ret_valid = 0;
  logic [2:0] ret_reg = 0;
  logic [5:0] ret_tag = 0;
  logic [17:0] a_tag, b_tag;
  logic [2:0]  a_inf, b_inf;
  int m_busy [8], m_tag [8];
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  reg_alias_table u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .op_valid(v), .op_writes(w),
    .op_src_a({sa[2], sa[1], sa[0]}), .op_src_b({sb[2], sb[1], sb[0]}),
    .op_dst({d[2], d[1], d[0]}), .op_tag({t[2], t[1], t[0]}),
    .ret_valid(ret_valid), .ret_reg(ret_reg), .ret_tag(ret_tag),
    .src_a_tag(a_tag), .src_a_inflight(a_inf),
    .src_b_tag(b_tag), .src_b_inflight(b_inf));

  task automatic check_one(string lab, int k, int s, int gb, int gt, int eb, int et);
    checks++;
    if (gb != eb || (eb == 1 && gt != et)) begin
      fails++;
      $display("FAIL %s lane%0d src%0d: got busy=%0d tag=%0d, expected busy=%0d tag=%0d",
               lab, k, s, gb, gt, eb, et);
    end
  endtask

  task automatic compare(string lab);
    for (int k = 0; k < 3; k++)
      for (int s = 0; s < 2; s++) begin
        int r, eb, et, gb, gt;
        bit byp;
        r = (s == 0) ? int'(sa[k]) : int'(sb[k]);
        eb = m_busy[r]; et = m_tag[r]; byp = 0;
        for (int j = 0; j < k; j++)
          if (v[j] && w[j] && int'(d[j]) == r) begin eb = 1; et = int'(t[j]); byp = 1; end
        gb = (s == 0) ? int'(a_inf[k]) : int'(b_inf[k]);
        gt = (s == 0) ? int'(a_tag[k*6 +: 6]) : int'(b_tag[k*6 +: 6]);
        check_one(byp ? "R3" : lab, k, s, gb, gt, eb, et);
      end
  endtask

  task automatic model_update();
    if (flush) begin
      for (int r = 0; r < 8; r++) m_busy[r] = 0;
    end else begin
      if (ret_valid && m_tag[ret_reg] == int'(ret_tag)) m_busy[ret_reg] = 0;
      for (int k = 0; k < 3; k++)
        if (v[k] && w[k]) begin m_busy[d[k]] = 1; m_tag[d[k]] = int'(t[k]); end
    end
  endtask

  task automatic step(string lab);
    #1 compare(lab);
    @(posedge clk);
    model_update();
    @(negedge clk);
    v = 0; w = 0; flush = 0; ret_valid = 0;
  endtask

  task automatic idle();
    v = 0; w = 0; flush = 0; ret_valid = 0;
  endtask

  task automatic probe(int r, int eb, int et, string lab);
    sa[0] = 3'(r);
    #1;
    check_one(lab, 0, 0, int'(a_inf[0]), int'(a_tag[5:0]), eb, et);
    check_one(lab, 0, 0, m_busy[r], m_tag[r], eb, et);
  endtask

  task automatic op(int k, int src_a, int src_b, int dst, int tag, bit val, bit wr);
    sa[k] = 3'(src_a); sb[k] = 3'(src_b); d[k] = 3'(dst); t[k] = 6'(tag);
    v[k] = val; w[k] = wr;
  endtask

  initial begin
    for (int k = 0; k < 3; k++) begin sa[k] = 0; sb[k] = 0; d[k] = 0; t[k] = 0; end
    for (int r = 0; r < 8; r++) begin m_busy[r] = 0; m_tag[r] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1: reset state
    for (int r = 0; r < 8; r++) begin
      probe(r, 0, 0, "R1");
      checks++;
      if (a_tag[5:0] != 0) begin fails++; $display("FAIL R1 tag r%0d got %0d expected 0", r, a_tag[5:0]); end
    end

    // R4: single rename
    idle(); op(0, 1, 1, 2, 5, 1, 1); step("R2");
    probe(2, 1, 5, "R4");

    // R5 and R3: three lanes write r4
    op(0, 4, 0, 4, 10, 1, 1); op(1, 4, 4, 4, 11, 1, 1); op(2, 4, 2, 4, 12, 1, 1); step("R2");
    probe(4, 1, 12, "R5");

    // R6: stale retire ignored, matching retire clears
    ret_valid = 1; ret_reg = 2; ret_tag = 9; step("R2");
    probe(2, 1, 5, "R6");
    ret_valid = 1; ret_reg = 2; ret_tag = 5; step("R2");
    probe(2, 0, 5, "R6");

    // R7: retire and rename of same register in one cycle
    op(0, 0, 0, 3, 7, 1, 1); step("R2");
    ret_valid = 1; ret_reg = 3; ret_tag = 7; op(1, 3, 3, 3, 20, 1, 1); step("R2");
    probe(3, 1, 20, "R7");

    // R9: invalid lane and non-writing lane
    op(0, 6, 6, 6, 30, 0, 1); op(1, 6, 6, 5, 31, 1, 0); op(2, 6, 5, 0, 0, 0, 0); step("R9");
    probe(6, 0, 0, "R9");
    probe(5, 0, 0, "R9");

    // R8: flush discards same-cycle rename
    op(0, 0, 0, 1, 33, 1, 1); flush = 1; step("R2");
    for (int r = 0; r < 8; r++) probe(r, 0, m_tag[r], "R8");

    // random stream, model compared every cycle (R2/R3)
    for (int n = 0; n < 400; n++) begin
      for (int k = 0; k < 3; k++)
        op(k, $urandom % 8, $urandom % 8, $urandom % 8, $urandom % 40,
           ($urandom % 4) != 0, ($urandom % 3) != 0);
      flush = ($urandom % 25) == 0;
      ret_valid = ($urandom % 2) == 0;
      ret_reg = 3'($urandom % 8);
      ret_tag = ($urandom % 3 == 0) ? 6'($urandom % 40) : 6'(m_tag[ret_reg]);
      step("R2");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule